// File: doc/BRIEF.md
# Effective and Linear Address Generator

This block forms the memory address of a load or store for a 64-bit processor. It takes a base register value and an optional index register value. The index is scaled by 1, 2, 4 or 8. A displacement is added, either as a 32-bit value that is sign-extended or as a full 64-bit value. The result is the effective address. The effective address is cut down to the active address size of 16, 32 or 64 bits and zero-extended back to 64 bits. Only after that step is the full, never-truncated segment base added, which gives the linear address.

The block also flags a linear address that is not canonical. The number of implemented address bits is set by a parameter. All results are captured in one output register stage, one cycle after an input strobe. The register holds its contents until the next strobe. Decoding, paging, limit checks and fault delivery are handled elsewhere.

Top module: `agu_top`

## Requirements
- R1: In 64-bit size (`asize_i` = 2 or 3), `ea_o` equals base + (index << `scale_i`) + displacement, taken modulo 2^64. The scale selector values 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R2: With `disp_wide_i` = 0, only `disp_i[31:0]` is used, sign-extended from bit 31; `disp_i[63:32]` has no effect on any output.
- R3: With `disp_wide_i` = 1, all 64 bits of `disp_i` are added without extension.
- R4: With `index_en_i` = 0, the index term is zero, whatever the values of `index_i` and `scale_i`.
- R5: `asize_i` = 0 keeps sum bits 15:0 and `asize_i` = 1 keeps sum bits 31:0, with the upper bits of `ea_o` set to zero. Carries out of the kept width are dropped, so the address wraps. In these two sizes `ea_o[63:32]` is always zero.
- R6: `lin_o` equals `ea_o` + `seg_base_i`, taken modulo 2^64. The segment base is never truncated in any size, and with a zero segment base `lin_o` equals `ea_o`.
- R7: `non_canon_o` is 1 exactly when bits 63 down to IMPL_W-1 of `lin_o` are not all equal. With the default IMPL_W of 48, this is bits 63:47.
- R8: `valid_o` is 1 exactly in the cycle after a cycle with `valid_i` = 1. `ea_o`, `lin_o` and `non_canon_o` change only on a strobe and otherwise hold their values.
- R9: While `rst_ni` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe; operands are sampled when high |
| base_i | input | 64 | Base register value |
| index_i | input | 64 | Index register value |
| index_en_i | input | 1 | 1 = include the scaled index term |
| scale_i | input | 2 | Index shift amount (x1, x2, x4, x8) |
| disp_i | input | 64 | Displacement |
| disp_wide_i | input | 1 | 1 = use all 64 displacement bits; 0 = sign-extend bits 31:0 |
| seg_base_i | input | 64 | Segment base, always added in full |
| asize_i | input | 2 | Address size: 0 = 16-bit, 1 = 32-bit, 2 or 3 = 64-bit |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| ea_o | output | 64 | Truncated, zero-extended effective address |
| lin_o | output | 64 | Linear address |
| non_canon_o | output | 1 | Linear address is not canonical |

## Verification
Every result is due exactly one clock edge after its strobe. `valid_o`, `ea_o`, `lin_o` and `non_canon_o` all appear together, with no further latency. The driver applies each operand set on a falling edge and queues its expected result. The monitor samples on every falling edge. Whenever `valid_o` is high it pops one expected item, so a result that arrives a cycle early or late is compared against the wrong item or finds an empty queue. In cycles without a strobe, the monitor checks that the address outputs still hold the last result while the inputs are driven with junk.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int ADDR_W   = 64;
  localparam int NARROW16 = 16;
  localparam int NARROW32 = 32;

  typedef enum logic [1:0] {
    ASZ_16  = 2'd0,
    ASZ_32  = 2'd1,
    ASZ_64  = 2'd2,
    ASZ_64X = 2'd3
  } asize_e;
endpackage

// File: rtl/agu_ea_calc.sv
module agu_ea_calc
  import agu_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int DISP_W = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic          index_en_i,
  input  logic [1:0]    scale_i,
  input  logic [AW-1:0] disp_i,
  input  logic          disp_wide_i,
  input  logic [1:0]    asize_i,
  output logic [AW-1:0] ea_o
);
  localparam int EXT_W = AW - DISP_W;

  logic [AW-1:0] disp_ext;
  logic [AW-1:0] idx_term;
  logic [AW-1:0] raw_sum;

  always_comb begin
    disp_ext = disp_wide_i ? disp_i
                           : {{EXT_W{disp_i[DISP_W-1]}}, disp_i[DISP_W-1:0]};
    idx_term = index_en_i ? (index_i << scale_i) : '0;
    raw_sum  = base_i + idx_term + disp_ext;
  end

  // truncate to active size, then zero-extend; carries past the width drop
  always_comb begin
    unique case (asize_e'(asize_i))
      ASZ_16:  ea_o = {{(AW-NARROW16){1'b0}}, raw_sum[NARROW16-1:0]};
      ASZ_32:  ea_o = {{(AW-NARROW32){1'b0}}, raw_sum[NARROW32-1:0]};
      default: ea_o = raw_sum;
    endcase
  end
endmodule

// File: rtl/agu_canon_chk.sv
module agu_canon_chk #(
  parameter int AW     = 64,
  parameter int IMPL_W = 48
) (
  input  logic [AW-1:0] lin_i,
  output logic          non_canon_o
);
  generate
    if (IMPL_W >= AW) begin : g_full
      logic unused_lin;
      assign unused_lin  = ^lin_i;
      assign non_canon_o = 1'b0;
    end else begin : g_part
      localparam int TOP_W = AW - IMPL_W + 1;
      logic [TOP_W-1:0] top_bits;
      assign top_bits    = lin_i[AW-1:IMPL_W-1];
      assign non_canon_o = !((&top_bits) || (~|top_bits));
    end
  endgenerate
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int IMPL_W = 48,
  parameter int DISP_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic              index_en_i,
  input  logic [1:0]        scale_i,
  input  logic [ADDR_W-1:0] disp_i,
  input  logic              disp_wide_i,
  input  logic [ADDR_W-1:0] seg_base_i,
  input  logic [1:0]        asize_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic [ADDR_W-1:0] lin_o,
  output logic              non_canon_o
);
  localparam int AW = ADDR_W;

  logic [AW-1:0] ea_d;
  logic [AW-1:0] lin_d;
  logic          nc_d;

  agu_ea_calc #(.AW(AW), .DISP_W(DISP_W)) u_ea (
    .base_i      (base_i),
    .index_i     (index_i),
    .index_en_i  (index_en_i),
    .scale_i     (scale_i),
    .disp_i      (disp_i),
    .disp_wide_i (disp_wide_i),
    .asize_i     (asize_i),
    .ea_o        (ea_d)
  );

  // segment base added in full after truncation
  assign lin_d = ea_d + seg_base_i;

  agu_canon_chk #(.AW(AW), .IMPL_W(IMPL_W)) u_canon (
    .lin_i       (lin_d),
    .non_canon_o (nc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      ea_o        <= '0;
      lin_o       <= '0;
      non_canon_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        ea_o        <= ea_d;
        lin_o       <= lin_d;
        non_canon_o <= nc_d;
      end
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(ea_o) && $stable(lin_o) && $stable(non_canon_o))); // R8
  AST_SEG_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (lin_o == ea_o + $past(seg_base_i))); // R6
  AST_NARROW_LOW4G: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ($past(asize_i) < 2'd2)) |-> (ea_o[AW-1:NARROW32] == '0)); // R5
  AST_NARROW16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ($past(asize_i) == 2'd0)) |-> (ea_o[AW-1:NARROW16] == '0)); // R5

  generate
    if (IMPL_W < AW) begin : g_canon_ast
      AST_CANON_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !non_canon_o) |->
          ((lin_o[AW-1:IMPL_W-1] == '0) || (&lin_o[AW-1:IMPL_W-1]))); // R7
    end
  endgenerate
endmodule

// File: tb/agu_top_tb.sv
`timescale 1ns/1ps
module agu_top_tb;
  localparam int IMPL_W = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] base_i = '0, index_i = '0, disp_i = '0, seg_base_i = '0;
  logic        index_en_i = 1'b0, disp_wide_i = 1'b0;
  logic [1:0]  scale_i = '0, asize_i = '0;
  logic        valid_o, non_canon_o;
  logic [63:0] ea_o, lin_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] ea;
    logic [63:0] lin;
    logic        nc;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  exp_t        last;
  bit          have_last = 0;

  always #2 clk = ~clk;

  agu_top #(.IMPL_W(IMPL_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .base_i(base_i), .index_i(index_i), .index_en_i(index_en_i),
    .scale_i(scale_i), .disp_i(disp_i), .disp_wide_i(disp_wide_i),
    .seg_base_i(seg_base_i), .asize_i(asize_i),
    .valid_o(valid_o), .ea_o(ea_o), .lin_o(lin_o), .non_canon_o(non_canon_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [63:0] b, input logic [63:0] x,
                                 input logic xe, input logic [1:0] sc,
                                 input logic [63:0] d, input logic dw,
                                 input logic [63:0] sg, input logic [1:0] az,
                                 input string tag);
    exp_t r;
    logic [63:0] dd, s, top_mask;
    dd = dw ? d : {{32{d[31]}}, d[31:0]};
    s  = b + (xe ? (x * (64'd1 << sc)) : 64'd0) + dd;
    case (az)
      2'd0:    r.ea = s & 64'h0000_0000_0000_FFFF;
      2'd1:    r.ea = s & 64'h0000_0000_FFFF_FFFF;
      default: r.ea = s;
    endcase
    r.lin = r.ea + sg;
    top_mask = ~((64'd1 << (IMPL_W - 1)) - 64'd1);
    r.nc  = !(((r.lin & top_mask) == 64'd0) || ((r.lin & top_mask) == top_mask));
    r.tag = tag;
    return r;
  endfunction

  task automatic send(input logic [63:0] b, input logic [63:0] x, input logic xe,
                      input logic [1:0] sc, input logic [63:0] d, input logic dw,
                      input logic [63:0] sg, input logic [1:0] az, input string tag);
    @(negedge clk);
    valid_i = 1'b1; base_i = b; index_i = x; index_en_i = xe; scale_i = sc;
    disp_i = d; disp_wide_i = dw; seg_base_i = sg; asize_i = az;
    sb_q.push_back(model(b, x, xe, sc, d, dw, sg, az, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      base_i = {$urandom, $urandom}; index_i = {$urandom, $urandom};
      disp_i = {$urandom, $urandom}; seg_base_i = {$urandom, $urandom};
      asize_i = 2'($urandom); scale_i = 2'($urandom);
      index_en_i = 1'($urandom); disp_wide_i = 1'($urandom);
    end
  endtask

  // monitor: results due one edge after strobe
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (valid_o) begin
          if (sb_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL R8 unexpected valid_o actual=1 expected=0");
          end else begin
            last = sb_q.pop_front();
            have_last = 1;
            chk({last.tag, " ea"},  ea_o,  last.ea);
            chk({last.tag, " lin"}, lin_o, last.lin);
            chk({last.tag, " nc"},  {63'd0, non_canon_o}, {63'd0, last.nc});
          end
        end else if (have_last) begin
          chk("R8 hold ea",  ea_o,  last.ea);
          chk("R8 hold lin", lin_o, last.lin);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset valid", {63'd0, valid_o}, 64'd0);
    chk("R9 reset ea", ea_o, 64'd0);
    chk("R9 reset lin", lin_o, 64'd0);
    chk("R9 reset nc", {63'd0, non_canon_o}, 64'd0);
    rst_n = 1'b1;
    idle(2);

    // R1 scaled sums, each scale
    for (int sc = 0; sc < 4; sc++)
      send(64'h1000, 64'h10, 1, 2'(sc), 64'h20, 0, 64'd0, 2'd2, "R1 scale");
    send(64'hFFFF_FFFF_FFFF_FFF0, 64'h4, 1, 2'd3, 64'h0, 0, 64'd0, 2'd3, "R1 wrap64");
    idle(2);
    // R2 negative narrow displacement, junk upper bits ignored
    send(64'h0000_0000_0010_0000, 64'h0, 0, 2'd0, 64'hDEAD_BEEF_FFFF_FFF0, 0, 64'd0, 2'd2, "R2 sext");
    send(64'h500, 64'h0, 0, 2'd0, 64'h1234_5678_0000_0100, 0, 64'd0, 2'd2, "R2 upper");
    // R3 wide displacement
    send(64'h0, 64'h0, 0, 2'd0, 64'h0000_8000_0000_0000, 1, 64'd0, 2'd2, "R3 wide");
    send(64'h10, 64'h0, 0, 2'd0, 64'h1234_5678_9ABC_DEF0, 1, 64'd0, 2'd2, "R3 wide2");
    idle(1);
    // R4 index disabled
    send(64'h2000, 64'hFFFF_0000_1234_0000, 0, 2'd3, 64'h8, 0, 64'd0, 2'd2, "R4 noidx");
    // R5 truncation and wrap
    send(64'hFFF0, 64'h0, 0, 2'd0, 64'h20, 0, 64'd0, 2'd0, "R5 wrap16");
    send(64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 0, 2'd0, 64'h20, 0, 64'd0, 2'd1, "R5 wrap32");
    send(64'h1234_5678_9ABC_DEF0, 64'h1, 1, 2'd1, 64'h0, 0, 64'd0, 2'd0, "R5 cut16");
    idle(3);
    // R6 full segment base after truncation
    send(64'hFFF0, 64'h0, 0, 2'd0, 64'h20, 0, 64'hFFFF_FFFF_0000_0000, 2'd0, "R6 seg16");
    send(64'hFFFF_FFF0, 64'h0, 0, 2'd0, 64'h20, 0, 64'h0000_0001_0000_0000, 2'd1, "R6 seg32");
    send(64'h4000, 64'h0, 0, 2'd0, 64'h0, 0, 64'hFFFF_FFFF_FFFF_F000, 2'd2, "R6 seg64");
    // R7 canonical boundaries
    send(64'h0000_7FFF_FFFF_FFFF, 64'h0, 0, 2'd0, 64'h0, 0, 64'd0, 2'd2, "R7 lowmax");
    send(64'h0000_8000_0000_0000, 64'h0, 0, 2'd0, 64'h0, 0, 64'd0, 2'd2, "R7 lowbad");
    send(64'hFFFF_8000_0000_0000, 64'h0, 0, 2'd0, 64'h0, 0, 64'd0, 2'd2, "R7 highmin");
    send(64'hFFFF_7FFF_FFFF_FFFF, 64'h0, 0, 2'd0, 64'h0, 0, 64'd0, 2'd2, "R7 highbad");
    send(64'h0, 64'h0, 0, 2'd0, 64'h0, 0, 64'h0001_0000_0000_0000, 2'd2, "R7 segbad");
    idle(4);
    // R8 strobe after long idle
    send(64'hABCD, 64'h3, 1, 2'd2, 64'hFFFF_FFFF, 0, 64'h100, 2'd1, "R8 after idle");
    idle(4);

    done = 1;
    if (sb_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R8 pending results actual=%0d expected=0", sb_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule